// File: doc/BRIEF.md
# NAND Sector ECC Syndrome Classifier and Bit Fixer

This block takes two 3-byte error-correcting codes belonging to one 512-byte NAND sector. The first is the code stored with the sector. The second is the code freshly computed over the data as it was read back. From the two codes it decides what kind of damage the sector has suffered.

The two codes are reordered into 24-bit syndrome words and combined by XOR. The resulting difference word is then sorted into one of four classes:
- no error;
- a single flipped data bit, which can be corrected;
- damage confined to the code bytes themselves;
- an uncorrectable error.

For a correctable error the block reports the byte address (9 bits) and the bit position (3 bits) of the bad bit.

A streaming port lets the sector be passed through the block after the check. Each byte is presented with its index. The byte that matches the reported address comes out with the reported bit inverted. Every other byte passes unchanged. The result of the latest check stays in force until the next check strobe.

Top module: `nand_ecc_fixer`

## Requirements
- R1: Each code port carries its three bytes as {byte2, byte1, byte0}. The syndrome word is that 24-bit value rotated left by 6 bit positions, which gives {byte2[1:0], byte1, byte0, byte2[7:2]}. The difference word is the XOR of the stored and computed syndrome words. When the two codes are identical, the status is 00 (clean).
- R2: When every one of the 12 bit pairs (bits 2k and 2k+1, k = 0..11) of the difference word holds at least one set bit, the status is 01 (corrected data). In every other status, the reported byte address and bit position are zero.
- R3: For status 01, the bit position is {diff[5], diff[3], diff[1]}, with diff[1] as the least significant bit.
- R4: For status 01, the byte address is {diff[23], diff[21], ..., diff[9], diff[7]}, with diff[7] as the least significant bit.
- R5: When the pair test of R2 fails and exactly one bit of the difference word is set, the status is 10 (error in the code bytes only).
- R6: Every other nonzero difference word gives status 11 (uncorrectable).
- R7: statusValid is high for exactly the one cycle after a cycle with checkValid high. The status, byte address and bit position change only in that cycle and hold until the next check.
- R8: A byte presented with streamValid appears on outData in the following cycle, with outValid high. If the held status is 01 and streamIndex equals the held byte address, the byte is XORed with (1 << bit position).
- R9: When the held status is not 01, or the index does not match, the byte passes through unchanged.
- R10: After reset the status is 00, the byte address and bit position are 0, and statusValid and outValid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| checkValid | input | 1 | Strobe: compare the two codes this cycle |
| storedEcc | input | 24 | Code read from spare area, {byte2, byte1, byte0} |
| calcEcc | input | 24 | Code recomputed over the data, {byte2, byte1, byte0} |
| statusValid | output | 1 | One-cycle pulse when a new result is out |
| statusCode | output | 2 | 00 clean, 01 corrected, 10 code-only, 11 uncorrectable |
| errByte | output | 9 | Byte address of the bad bit |
| errBit | output | 3 | Bit position within that byte |
| streamValid | input | 1 | Sector byte present on the stream inputs |
| streamIndex | input | 9 | Index of the streamed byte in the sector |
| streamData | input | 8 | Streamed sector byte |
| outValid | output | 1 | Fixed byte present on outData |
| outData | output | 8 | Streamed byte after fix-up |

## Verification
The classification result is registered once. Status, address, position and statusValid are therefore due in the cycle after the check strobe. The bench drives the strobe on a falling edge and samples all four on the next falling edge. It then samples once more to see statusValid drop while the result holds.

The stream path is also one register deep. Each byte is driven on a falling edge and its fixed copy is compared one falling edge later, against the status the bench expects to be held. Expected classes come from bench functions that apply the pair, single-bit and zero tests directly to the difference word the bench chose.

// File: rtl/nfx_pkg.sv
package nfx_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_FIXED    = 2'b01,
    ST_ECC_ONLY = 2'b10,
    ST_FATAL    = 2'b11
  } status_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadResult;
    logic passByte;
  } ctrl_s;
endpackage

// File: rtl/nfx_control.sv
module nfx_control
  import nfx_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  checkValid,
  input  logic  streamValid,
  output ctrl_s ctrl,
  output logic  statusValid,
  output logic  outValid
);
  always_comb begin
    ctrl.loadResult = checkValid;
    ctrl.passByte   = streamValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusValid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      statusValid <= checkValid;
      outValid    <= streamValid;
    end
  end
endmodule

// File: rtl/nfx_datapath.sv
module nfx_datapath
  import nfx_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_s                       ctrl,
  input  logic [2*(ADDR_W+BIT_W)-1:0] storedEcc,
  input  logic [2*(ADDR_W+BIT_W)-1:0] calcEcc,
  input  logic [ADDR_W-1:0]           streamIndex,
  input  logic [DATA_W-1:0]           streamData,
  output logic [1:0]                  statusCode,
  output logic [ADDR_W-1:0]           errByte,
  output logic [BIT_W-1:0]            errBit,
  output logic [DATA_W-1:0]           outData
);
  localparam int PAIRS = ADDR_W + BIT_W;
  localparam int SYN_W = 2 * PAIRS;
  localparam int ROT   = 2 * BIT_W;

  logic [SYN_W-1:0]  storedWord, calcWord, diff;
  logic [PAIRS-1:0]  pairHit;
  logic [BIT_W-1:0]  bitLoc;
  logic [ADDR_W-1:0] byteLoc;
  logic              singleHot;
  status_e           classNext, statusQ;
  logic              fixHit;

  // reorder: rotate each code left so the bit-order field sits lowest
  assign storedWord = {storedEcc[SYN_W-ROT-1:0], storedEcc[SYN_W-1:SYN_W-ROT]};
  assign calcWord   = {calcEcc[SYN_W-ROT-1:0], calcEcc[SYN_W-1:SYN_W-ROT]};
  assign diff       = storedWord ^ calcWord;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pairHit[k] = diff[2*k] | diff[2*k+1];
  end
  for (genvar k = 0; k < BIT_W; k++) begin : g_bitLoc
    assign bitLoc[k] = diff[2*k+1];
  end
  for (genvar k = 0; k < ADDR_W; k++) begin : g_byteLoc
    assign byteLoc[k] = diff[2*(BIT_W+k)+1];
  end

  assign singleHot = (diff != '0) && ((diff & (diff - 1'b1)) == '0);

  always_comb begin
    if (diff == '0)        classNext = ST_CLEAN;
    else if (&pairHit)     classNext = ST_FIXED;
    else if (singleHot)    classNext = ST_ECC_ONLY;
    else                   classNext = ST_FATAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= ST_CLEAN;
      errByte <= '0;
      errBit  <= '0;
    end else if (ctrl.loadResult) begin
      statusQ <= classNext;
      errByte <= (classNext == ST_FIXED) ? byteLoc : '0;
      errBit  <= (classNext == ST_FIXED) ? bitLoc  : '0;
    end
  end

  assign statusCode = statusQ;
  assign fixHit     = (statusQ == ST_FIXED) && (streamIndex == errByte);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
    end else if (ctrl.passByte) begin
      outData <= streamData ^ (fixHit ? DATA_W'(1) << errBit : '0);
    end
  end
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import nfx_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        checkValid,
  input  logic [2*(ADDR_W+BIT_W)-1:0] storedEcc,
  input  logic [2*(ADDR_W+BIT_W)-1:0] calcEcc,
  output logic                        statusValid,
  output logic [1:0]                  statusCode,
  output logic [ADDR_W-1:0]           errByte,
  output logic [BIT_W-1:0]            errBit,
  input  logic                        streamValid,
  input  logic [ADDR_W-1:0]           streamIndex,
  input  logic [DATA_W-1:0]           streamData,
  output logic                        outValid,
  output logic [DATA_W-1:0]           outData
);
  ctrl_s ctrl;

  nfx_control u_ctrl (
    .clk(clk), .rstN(rstN), .checkValid(checkValid), .streamValid(streamValid),
    .ctrl(ctrl), .statusValid(statusValid), .outValid(outValid)
  );

  nfx_datapath #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .storedEcc(storedEcc), .calcEcc(calcEcc),
    .streamIndex(streamIndex), .streamData(streamData), .statusCode(statusCode),
    .errByte(errByte), .errBit(errBit), .outData(outData)
  );
endmodule

// File: rtl/nfx_checker.sv
module nfx_checker #(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        checkValid,
  input logic [2*(ADDR_W+BIT_W)-1:0] storedEcc,
  input logic [2*(ADDR_W+BIT_W)-1:0] calcEcc,
  input logic                        statusValid,
  input logic [1:0]                  statusCode,
  input logic [ADDR_W-1:0]           errByte,
  input logic [BIT_W-1:0]            errBit,
  input logic                        streamValid,
  input logic [DATA_W-1:0]           streamData,
  input logic                        outValid,
  input logic [DATA_W-1:0]           outData
);
  AST_CLEAN_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    checkValid && (storedEcc == calcEcc) |=> statusCode == 2'b00); // R1
  AST_LOC_ZERO_UNFIXED: assert property (@(posedge clk) disable iff (!rstN)
    statusValid && (statusCode != 2'b01) |-> (errByte == '0) && (errBit == '0)); // R2
  AST_ONE_BIT_CODE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    checkValid && ($countones(storedEcc ^ calcEcc) == 1) |=> statusCode == 2'b10); // R5
  AST_MANY_BITS_NOT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    checkValid && ($countones(storedEcc ^ calcEcc) > 1) |=> statusCode != 2'b00); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    checkValid |=> statusValid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> !statusValid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> $stable(statusCode) && $stable(errByte) && $stable(errBit)); // R7
  AST_STREAM_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    streamValid |=> outValid); // R8
  AST_FIX_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    streamValid && (statusCode == 2'b01) |=> $countones(outData ^ $past(streamData)) <= 1); // R8
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    streamValid && (statusCode != 2'b01) |=> outData == $past(streamData)); // R9
endmodule

bind nand_ecc_fixer nfx_checker #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .checkValid(checkValid), .storedEcc(storedEcc),
  .calcEcc(calcEcc), .statusValid(statusValid), .statusCode(statusCode),
  .errByte(errByte), .errBit(errBit), .streamValid(streamValid),
  .streamData(streamData), .outValid(outValid), .outData(outData)
);

// File: tb/nand_ecc_fixer_tb_top.sv
`timescale 1ns/1ps
module nand_ecc_fixer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        checkValid = 1'b0;
  logic [23:0] storedEcc = '0, calcEcc = '0;
  logic        statusValid;
  logic [1:0]  statusCode;
  logic [8:0]  errByte;
  logic [2:0]  errBit;
  logic        streamValid = 1'b0;
  logic [8:0]  streamIndex = '0;
  logic [7:0]  streamData = '0;
  logic        outValid;
  logic [7:0]  outData;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0] expStatus = 2'b00;
  logic [8:0] expByte = '0;
  logic [2:0] expBit = '0;

  always #2.5 clk = ~clk;

  nand_ecc_fixer dut_i (
    .clk(clk), .rstN(rstN), .checkValid(checkValid), .storedEcc(storedEcc),
    .calcEcc(calcEcc), .statusValid(statusValid), .statusCode(statusCode),
    .errByte(errByte), .errBit(errBit), .streamValid(streamValid),
    .streamIndex(streamIndex), .streamData(streamData), .outValid(outValid),
    .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // difference word to the matching raw 3-byte XOR: rotate right by 6
  function automatic logic [23:0] rawOf(input logic [23:0] w);
    return {w[5:0], w[23:6]};
  endfunction

  function automatic logic [1:0] classOf(input logic [23:0] d);
    bit allPairs = 1;
    for (int k = 0; k < 12; k++) if (!(d[2*k] | d[2*k+1])) allPairs = 0;
    if (d == 0) return 2'b00;
    if (allPairs) return 2'b01;
    if ($countones(d) == 1) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [2:0] bitOf(input logic [23:0] d);
    return {d[5], d[3], d[1]};
  endfunction

  function automatic logic [8:0] byteOf(input logic [23:0] d);
    logic [8:0] b;
    for (int k = 0; k < 9; k++) b[k] = d[7 + 2*k];
    return b;
  endfunction

  task automatic runCheck(input logic [23:0] stored, input logic [23:0] d);
    logic [1:0] c;
    string tag;
    c = classOf(d);
    tag = (c == 2'b00) ? "R1" : (c == 2'b01) ? "R2" : (c == 2'b10) ? "R5" : "R6";
    expStatus = c;
    expByte = (c == 2'b01) ? byteOf(d) : '0;
    expBit  = (c == 2'b01) ? bitOf(d) : '0;
    @(negedge clk);
    storedEcc = stored;
    calcEcc = stored ^ rawOf(d);
    checkValid = 1'b1;
    @(negedge clk);
    checkValid = 1'b0;
    storedEcc = $urandom;
    calcEcc = $urandom;
    chk(statusValid === 1'b1, "R7", "statusValid pulse", statusValid, 1);
    chk(statusCode === expStatus, tag, "statusCode", statusCode, expStatus);
    chk(errBit === expBit, (c == 2'b01) ? "R3" : "R2", "errBit", errBit, expBit);
    chk(errByte === expByte, (c == 2'b01) ? "R4" : "R2", "errByte", errByte, expByte);
    @(negedge clk);
    chk(statusValid === 1'b0, "R7", "statusValid drop", statusValid, 0);
    chk(statusCode === expStatus && errByte === expByte && errBit === expBit,
        "R7", "result hold", statusCode, expStatus);
  endtask

  task automatic runStream();
    logic [7:0] d, e;
    for (int i = 0; i < 512; i++) begin
      d = 8'($urandom);
      streamValid = 1'b1;
      streamIndex = 9'(i);
      streamData = d;
      @(negedge clk);
      e = d;
      if (expStatus == 2'b01 && 9'(i) == expByte) e = d ^ (8'd1 << expBit);
      chk(outValid === 1'b1, "R8", "outValid", outValid, 1);
      chk(outData === e, (e != d) ? "R8" : "R9", "outData", outData, e);
    end
    streamValid = 1'b0;
    @(negedge clk);
    chk(outValid === 1'b0, "R8", "outValid drop", outValid, 0);
  endtask

  function automatic logic [23:0] randCorrectable();
    logic [23:0] d;
    for (int k = 0; k < 12; k++) begin
      int r = 1 + int'($urandom % 3);
      d[2*k+:2] = 2'(r);
    end
    return d;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(statusCode === 2'b00 && errByte === 0 && errBit === 0, "R10", "reset result",
        statusCode, 0);
    chk(statusValid === 1'b0 && outValid === 1'b0, "R10", "reset valids",
        {statusValid, outValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R9: stream before any check passes unchanged
    runStream();
    // directed corners
    runCheck(24'hA5C33C, 24'h000000);      // R1 clean
    runCheck(24'h123456, 24'h555555);      // R2: byte 0 bit 0
    runStream();
    runCheck(24'h00FF00, 24'hAAAAAA);      // R4: byte 511 bit 7
    runStream();
    runCheck(24'h777777, 24'hFFFFFF);      // R3: both pair bits set, byte 511 bit 7
    runCheck(24'h0F0F0F, 24'h000001);      // R5 lowest bit
    runStream();                           // R9 code-only: no flip
    runCheck(24'h0F0F0F, 24'h800000);      // R5 highest bit
    runCheck(24'h000000, 24'h000003);      // R6 two bits
    runStream();
    runCheck(24'hFFFFFF, 24'h555554);      // R6 one pair empty
    runCheck(24'h13579B, 24'h5555D6);      // R2/R3/R4 mixed location
    runStream();
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [23:0] d;
      case ($urandom % 4)
        0: d = '0;
        1: d = 24'd1 << ($urandom % 24);
        2: d = randCorrectable();
        default: d = 24'($urandom);
      endcase
      runCheck(24'($urandom), d);
      if (n % 100 == 7) runStream();
    end
    runCheck(24'($urandom), randCorrectable());
    runStream();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule